// File: doc/BRIEF.md
# Page Translation Cache with Line and Full Invalidation

This block caches recent virtual-page to physical-page translations in front of a page-table walker. It is fully associative over a small number of entries. A lookup presents a 32-bit virtual address. If a valid entry carries that page tag, the block answers in the same cycle with the physical address and the read and write permission bits. Otherwise it raises a request to the walker.

When the walker finishes, it installs its result through the fill port. Software keeps the cache coherent with the page tables in two ways. It can write one virtual address to drop the single entry that covers that page. It can also issue a command that empties the whole cache, for example before translation resumes after a fault has been serviced. Neither kind of invalidation may leave a stale translation that a later lookup could still see.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: Pages are 4 KiB. A lookup hits when a valid entry's tag equals address bits 31:12. It then returns the physical address {frame, address bits 11:0} and the stored read and write bits. On a miss the physical address and both permission bits are zero. A fill becomes visible to lookups from the cycle after it is presented.
- R3: The walker request is high exactly when a lookup is presented and misses. The hit output is high only while a lookup is presented.
- R4: A line invalidation removes only the entry whose tag equals bits 31:12 of the invalidation address. All other entries stay intact.
- R5: A full invalidation removes every entry in one cycle.
- R6: Invalidation wins over a fill in the same cycle. A fill presented together with a full invalidation is dropped. A fill presented together with a line invalidation of the same page is also dropped. A fill presented with a line invalidation of a different page is installed.
- R7: A new page is placed in the lowest-numbered invalid entry if any entry is invalid. This does not move the replacement pointer.
- R8: When every entry is valid, a new page replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset and then advances by one, wrapping around.
- R9: A fill whose page is already cached overwrites that entry in place. The cache never holds two entries for one page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup presented |
| lkp_vaddr_i | input | 32 | Virtual address to translate |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_paddr_o | output | 32 | Translated physical address |
| lkp_rd_o | output | 1 | Read permitted |
| lkp_wr_o | output | 1 | Write permitted |
| walk_req_o | output | 1 | Lookup missed; walker needed |
| fill_valid_i | input | 1 | Install a walker result |
| fill_vpn_i | input | 20 | Virtual page number of the fill |
| fill_pfn_i | input | 20 | Physical frame number of the fill |
| fill_rd_i | input | 1 | Read permission of the fill |
| fill_wr_i | input | 1 | Write permission of the fill |
| inv_line_i | input | 1 | Invalidate the page of inv_vaddr_i |
| inv_vaddr_i | input | 32 | Address whose page is invalidated |
| inv_all_i | input | 1 | Invalidate all entries |

## Verification
The bench uses the default of eight entries. With that size, nine distinct fills are enough to fill the cache and force the first round-robin eviction. A second wrap of the pointer also stays within a short directed sequence. Eight entries are likewise enough to open a hole with a line invalidation and watch it being reused ahead of the pointer. The same sequences cover refills of a page that is already cached and fills that collide with invalidations.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PG_W   = 12;
  localparam int unsigned VPN_W  = VA_W - PG_W;

  typedef struct packed {
    logic rd;
    logic wr;
  } perm_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] pfn;
    perm_t            perm;
  } xc_entry_t;
endpackage

// File: rtl/xc_victim_sel.sv
module xc_victim_sel #(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] valid_i,
  input  logic             alloc_i,
  output logic [N_ENT-1:0] victim_oh_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [N_ENT-1:0] free_oh;
  logic             all_valid;
  logic             adv;

  assign all_valid = &valid_i;
  assign adv       = alloc_i & all_valid;

  // lowest invalid entry first
  always_comb begin
    free_oh = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_oh = N_ENT'(1) << i;
    end
  end

  always_comb begin
    victim_oh_o = free_oh;
    if (all_valid) victim_oh_o = N_ENT'(1) << ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (adv) begin
      if (ptr_q == IDX_W'(N_ENT - 1)) ptr_q <= '0;
      else                            ptr_q <= ptr_q + 1'b1;
    end
  end

  p_victim_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_valid |-> ((victim_oh_o & valid_i) == '0));
  p_victim_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(victim_oh_o));
  p_ptr_moves_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && all_valid) |=> (ptr_q != $past(ptr_q)));
  p_ptr_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !all_valid) |=> $stable(ptr_q));
endmodule

// File: rtl/xc_entry_array.sv
module xc_entry_array
  import xlat_cache_pkg::*;
#(
  parameter int unsigned N_ENT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  output logic             lkp_match_o,
  output xc_entry_t        lkp_entry_o,
  input  logic             fill_valid_i,
  input  xc_entry_t        fill_entry_i,
  input  logic             inv_line_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             inv_all_i,
  input  logic [N_ENT-1:0] victim_oh_i,
  output logic [N_ENT-1:0] valid_o,
  output logic             alloc_o
);
  logic      [N_ENT-1:0] valid_q;
  xc_entry_t             ent_q [N_ENT];
  logic      [N_ENT-1:0] lkp_hit_vec, inv_hit_vec, fill_hit_vec, wr_sel;
  logic                  fill_en;

  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_cmp
      assign lkp_hit_vec[g]  = valid_q[g] && (ent_q[g].vpn == lkp_vpn_i);
      assign inv_hit_vec[g]  = valid_q[g] && (ent_q[g].vpn == inv_vpn_i);
      assign fill_hit_vec[g] = valid_q[g] && (ent_q[g].vpn == fill_entry_i.vpn);
    end
  endgenerate

  // invalidation beats a colliding fill
  assign fill_en = fill_valid_i && !inv_all_i &&
                   !(inv_line_i && (inv_vpn_i == fill_entry_i.vpn));
  assign alloc_o = fill_en && (fill_hit_vec == '0);
  assign wr_sel  = !fill_en ? '0 : ((fill_hit_vec != '0) ? fill_hit_vec : victim_oh_i);
  assign valid_o = valid_q;

  always_comb begin
    lkp_entry_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (lkp_hit_vec[i]) lkp_entry_o = lkp_entry_o | ent_q[i];
    end
  end
  assign lkp_match_o = |lkp_hit_vec;

  generate
    for (g = 0; g < N_ENT; g++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_q[g] <= 1'b0;
          ent_q[g]   <= '0;
        end else if (inv_all_i) begin
          valid_q[g] <= 1'b0;
        end else begin
          if (inv_line_i && inv_hit_vec[g]) valid_q[g] <= 1'b0;
          if (wr_sel[g]) begin
            valid_q[g] <= 1'b1;
            ent_q[g]   <= fill_entry_i;
          end
        end
      end
    end
  endgenerate

  function automatic logic [N_ENT-1:0] tag_hits(logic [VPN_W-1:0] t);
    logic [N_ENT-1:0] v;
    for (int i = 0; i < N_ENT; i++) v[i] = valid_q[i] && (ent_q[i].vpn == t);
    return v;
  endfunction

  p_single_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_hit_vec));
  p_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (valid_q == '0));
  p_line_gone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_line_i |=> (tag_hits($past(inv_vpn_i)) == '0));
  p_fill_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !inv_all_i && !(inv_line_i && inv_vpn_i == fill_entry_i.vpn))
      |=> (tag_hits($past(fill_entry_i.vpn)) != '0));
  p_fill_dropped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && inv_all_i) |=> (valid_q == '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int unsigned N_ENT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VA_W-1:0]   lkp_vaddr_i,
  output logic              lkp_hit_o,
  output logic [VA_W-1:0]   lkp_paddr_o,
  output logic              lkp_rd_o,
  output logic              lkp_wr_o,
  output logic              walk_req_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [VPN_W-1:0]  fill_pfn_i,
  input  logic              fill_rd_i,
  input  logic              fill_wr_i,
  input  logic              inv_line_i,
  input  logic [VA_W-1:0]   inv_vaddr_i,
  input  logic              inv_all_i
);
  logic             match;
  xc_entry_t        hit_ent, fill_ent;
  logic [N_ENT-1:0] valid_vec, victim_oh;
  logic             alloc;
  logic             unused_inv_off;

  assign unused_inv_off = ^inv_vaddr_i[PG_W-1:0];

  assign fill_ent.vpn     = fill_vpn_i;
  assign fill_ent.pfn     = fill_pfn_i;
  assign fill_ent.perm.rd = fill_rd_i;
  assign fill_ent.perm.wr = fill_wr_i;

  xc_entry_array #(.N_ENT(N_ENT)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lkp_vpn_i    (lkp_vaddr_i[VA_W-1:PG_W]),
    .lkp_match_o  (match),
    .lkp_entry_o  (hit_ent),
    .fill_valid_i (fill_valid_i),
    .fill_entry_i (fill_ent),
    .inv_line_i   (inv_line_i),
    .inv_vpn_i    (inv_vaddr_i[VA_W-1:PG_W]),
    .inv_all_i    (inv_all_i),
    .victim_oh_i  (victim_oh),
    .valid_o      (valid_vec),
    .alloc_o      (alloc)
  );

  xc_victim_sel #(.N_ENT(N_ENT)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_vec),
    .alloc_i     (alloc),
    .victim_oh_o (victim_oh)
  );

  assign lkp_hit_o   = lkp_valid_i && match;
  assign walk_req_o  = lkp_valid_i && !match;
  assign lkp_paddr_o = lkp_hit_o ? {hit_ent.pfn, lkp_vaddr_i[PG_W-1:0]} : '0;
  assign lkp_rd_o    = lkp_hit_o && hit_ent.perm.rd;
  assign lkp_wr_o    = lkp_hit_o && hit_ent.perm.wr;

  p_miss_or_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |-> (lkp_hit_o ^ walk_req_o));
  p_reset_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !lkp_hit_o);
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_vaddr = '0;
  logic        lkp_hit, lkp_rd, lkp_wr, walk_req;
  logic [31:0] lkp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        fill_rd = 1'b0, fill_wr = 1'b0;
  logic        inv_line = 1'b0;
  logic [31:0] inv_vaddr = '0;
  logic        inv_all = 1'b0;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  xlat_cache #(.N_ENT(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vaddr_i(lkp_vaddr),
    .lkp_hit_o(lkp_hit), .lkp_paddr_o(lkp_paddr), .lkp_rd_o(lkp_rd), .lkp_wr_o(lkp_wr),
    .walk_req_o(walk_req),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
    .fill_rd_i(fill_rd), .fill_wr_i(fill_wr),
    .inv_line_i(inv_line), .inv_vaddr_i(inv_vaddr), .inv_all_i(inv_all)
  );

  // behavioural reference
  bit          m_v   [N];
  bit [19:0]   m_tag [N];
  bit [19:0]   m_pfn [N];
  bit          m_rd  [N];
  bit          m_wr  [N];
  int          m_ptr = 0;

  function automatic bit [35:0] model_out();
    bit [35:0] r = '0;
    if (lkp_valid) begin
      r[0] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (m_v[i] && m_tag[i] == lkp_vaddr[31:12]) begin
          r = {m_wr[i], m_rd[i], m_pfn[i], lkp_vaddr[11:0], 1'b1, 1'b0};
        end
      end
    end
    return r; // {wr, rd, paddr, hit, req}
  endfunction

  task automatic model_step();
    bit en;
    int slot;
    en = fill_valid && !inv_all && !(inv_line && inv_vaddr[31:12] == fill_vpn);
    slot = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == fill_vpn) slot = i;
    if (en && slot < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    if (inv_all) for (int i = 0; i < N; i++) m_v[i] = 0;
    if (inv_line) for (int i = 0; i < N; i++)
      if (m_tag[i] == inv_vaddr[31:12]) m_v[i] = 0;
    if (en) begin
      m_v[slot] = 1; m_tag[slot] = fill_vpn; m_pfn[slot] = fill_pfn;
      m_rd[slot] = fill_rd; m_wr[slot] = fill_wr;
    end
  endtask

  // one clock: inputs set, outputs compared, model advanced
  task automatic cyc(string req);
    bit [35:0] exp_v, act_v;
    #1;
    exp_v = model_out();
    act_v = {lkp_wr, lkp_rd, lkp_paddr, lkp_hit, walk_req};
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s vaddr=%h act=%h exp=%h", req, lkp_vaddr, act_v, exp_v);
    end
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    fill_valid = 0; inv_line = 0; inv_all = 0; lkp_valid = 0;
  endtask

  task automatic look(bit [19:0] vpn, bit [11:0] off, string req);
    lkp_valid = 1; lkp_vaddr = {vpn, off};
    cyc(req);
  endtask

  task automatic fill(bit [19:0] vpn, bit [19:0] pfn, bit rd, bit wr);
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_rd = rd; fill_wr = wr;
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < 12; k++) look(20'h10 + 20'(k), 12'(k * 37), req);
    for (int k = 0; k < 4; k++) look(20'h40 + 20'(k), 12'h5a5, req);
    for (int k = 0; k < 4; k++) look(20'h50 + 20'(k), 12'h0ff, req);
    look(20'h60, 12'h001, req);
    look(20'h61, 12'h002, req);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = 0; m_pfn[i] = 0; m_rd[i] = 0; m_wr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: empty after reset
    sweep("R1");
    // R2 / R3: fill eight pages, lookup same cycle as fill misses
    for (int i = 0; i < N; i++) begin
      fill(20'h10 + 20'(i), 20'h800 + 20'(i * 3), i[0], i[1]);
      lkp_valid = 1; lkp_vaddr = {20'h10 + 20'(i), 12'h123};
      cyc("R2");
    end
    sweep("R2");
    look(20'h10, 12'hfff, "R3");
    lkp_vaddr = {20'h11, 12'h0}; cyc("R3"); // no lookup presented
    // R4: drop page 0x13 only
    inv_line = 1; inv_vaddr = {20'h13, 12'habc}; cyc("R4");
    sweep("R4");
    // R7: hole reused, pointer untouched
    fill(20'h40, 20'h900, 1, 1); cyc("R7");
    sweep("R7");
    // R8: full cache, round robin from entry 0
    fill(20'h50, 20'h910, 1, 0); cyc("R8");
    sweep("R8");
    fill(20'h51, 20'h911, 0, 1); cyc("R8");
    sweep("R8");
    for (int k = 2; k < 10; k++) begin fill(20'h50 + 20'(k % 4) + 20'h100, 20'h920 + 20'(k), 1, 1); cyc("R8"); end
    sweep("R8");
    look(20'h152, 12'h0, "R8");
    look(20'h153, 12'h0, "R8");
    // R9: refill in place, then single invalidation leaves no copy
    fill(20'h152, 20'hABCDE, 0, 1); cyc("R9");
    look(20'h152, 12'h777, "R9");
    inv_line = 1; inv_vaddr = {20'h152, 12'h0}; cyc("R9");
    look(20'h152, 12'h777, "R9");
    // R6: collisions with invalidation
    fill(20'h60, 20'h333, 1, 1); inv_line = 1; inv_vaddr = {20'h60, 12'h0}; cyc("R6");
    look(20'h60, 12'h001, "R6");
    fill(20'h61, 20'h334, 1, 0); inv_line = 1; inv_vaddr = {20'h153, 12'h0}; cyc("R6");
    look(20'h61, 12'h002, "R6");
    look(20'h153, 12'h002, "R6");
    fill(20'h62, 20'h335, 1, 1); inv_all = 1; cyc("R6");
    look(20'h62, 12'h0, "R6");
    // R5: refill then flush
    for (int i = 0; i < 5; i++) begin fill(20'h70 + 20'(i), 20'h500 + 20'(i), 1, 1); cyc("R5"); end
    look(20'h72, 12'h010, "R5");
    inv_all = 1; lkp_valid = 1; lkp_vaddr = {20'h73, 12'h0}; cyc("R5");
    for (int i = 0; i < 5; i++) look(20'h70 + 20'(i), 12'h010, "R5");
    sweep("R5");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule